// File: doc/BRIEF.md
# Link Controller Sleep Manager

This block chooses between the run, light-sleep and deep-sleep states of a serial bus link controller. It works from single-cycle pulses that mark the CPU's wait and stop instructions, together with a configuration bit, `wcm`, that sends a wait instruction into deep sleep. In light sleep the internal clock keeps running and the controller may not drive the bus. A correctly received message brings the block back to run and, when `ie` is set, raises a maskable interrupt. In deep sleep the internal clock is gated. The first passive-to-active edge on the raw bus level raises a non-maskable wake pulse. After that pulse the clock enable stays low for a fixed restart interval, which stands in for oscillator start-up.

The block also produces a flag that tells the receive path whether the byte that woke it can be trusted. That byte is only guaranteed when deep sleep was entered through a wait instruction after an end-of-frame had already been seen. The block leaves run only on instruction pulses, and it ignores every further instruction pulse until it returns to run.

Top module: `link_sleep_mgr`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `clk_en` is 1, `tx_inhibit` is 0, `irq` and `nmi_wake` are 0, and `rx_reliable` is 1.
- R2: In run, a `wait_pulse` with `wcm` = 0 (and no `stop_pulse`) enters light sleep at the next clock edge: `clk_en` stays 1 and `tx_inhibit` becomes 1.
- R3: In run, a `stop_pulse`, or a `wait_pulse` with `wcm` = 1, enters deep sleep at the next edge: `clk_en` becomes 0 and `tx_inhibit` becomes 1. When both pulses arrive in the same cycle, the stop pulse decides the entry, whatever the value of `wcm`.
- R4: In light sleep, a `msg_ok` pulse returns the block to run at the next edge (`tx_inhibit` = 0, `clk_en` = 1). On that same edge, `irq` is a one-cycle pulse if `ie` was 1 and stays 0 otherwise.
- R5: In deep sleep, a rise of `bus_level` from its passive value (parameter `BUS_PASSIVE`, default 0) to active produces a one-cycle `nmi_wake` pulse. The pulse comes `SYNC_STAGES`+1 edges after the change, which is 3 edges with the default. Bus activity in run or light sleep causes no `nmi_wake`, and `msg_ok` in deep sleep has no effect.
- R6: After `nmi_wake`, `clk_en` stays 0 and `tx_inhibit` stays 1 for `RESTART_CYCLES` cycles in total, counting the cycle of the pulse. On the next edge `clk_en` becomes 1 and `tx_inhibit` becomes 0 together.
- R7: `rx_reliable` becomes 1 on entry to light sleep. On entry to deep sleep it becomes 1 only if the entry came from a `wait_pulse` alone and `eof_seen` was 1 in the entry cycle; otherwise it becomes 0. Its value then holds until the next entry, whatever `eof_seen` does.
- R8: `wait_pulse` and `stop_pulse` have no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_pulse | input | 1 | One-cycle pulse: CPU executed a wait instruction |
| stop_pulse | input | 1 | One-cycle pulse: CPU executed a stop instruction |
| wcm | input | 1 | Configuration: 1 sends a wait instruction into deep sleep |
| ie | input | 1 | Configuration: enable the maskable wake interrupt |
| msg_ok | input | 1 | One-cycle pulse: a message was received without error |
| eof_seen | input | 1 | An end-of-frame has been detected on the bus |
| bus_level | input | 1 | Raw, unsynchronized bus level |
| clk_en | output | 1 | Enable for the controller's internal operating clock |
| tx_inhibit | output | 1 | 1 forbids the transmitter from driving the bus |
| irq | output | 1 | One-cycle maskable interrupt on wake from light sleep |
| nmi_wake | output | 1 | One-cycle non-maskable interrupt on bus wake from deep sleep |
| rx_reliable | output | 1 | The byte that woke the block will be received correctly |

## Verification
If the block holds the wrong state, the first sign is the `clk_en` and `tx_inhibit` pair one edge after an instruction pulse, since every output is registered from the next state. A lost or wrong entry route shows up in `rx_reliable` on that same edge. A restart counter with the wrong length moves the rise of `clk_en` away from exactly `RESTART_CYCLES` cycles after `nmi_wake`. A synchronizer of the wrong depth moves `nmi_wake` itself away from the third edge after the bus change. A state that accepts pulses it should ignore shows up as a change in `clk_en` or `tx_inhibit` one edge after a stray pulse, or as an `irq` or `nmi_wake` that has no cause.

// File: rtl/link_sleep_pkg.sv
package link_sleep_pkg;
  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_DOZE    = 2'd1,
    PM_HALT    = 2'd2,
    PM_RESTART = 2'd3
  } pm_state_e;
endpackage

// File: rtl/sleep_bus_sync.sv
module sleep_bus_sync #(
  parameter int   SYNC_STAGES = 2,
  parameter logic BUS_PASSIVE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_level,
  output logic wake_edge
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= BUS_PASSIVE;
        else if (g == 0) sync_q[g] <= bus_level;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= BUS_PASSIVE;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  assign wake_edge = (sync_q[SYNC_STAGES-1] != BUS_PASSIVE) && (last_q == BUS_PASSIVE);

  // R5
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    wake_edge |=> !wake_edge);
endmodule

// File: rtl/sleep_restart_timer.sv
module sleep_restart_timer #(
  parameter int RESTART_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = (RESTART_CYCLES < 2) ? 1 : $clog2(RESTART_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RESTART_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start)            cnt_q <= '0;
    else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  // R6
  timer_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/sleep_mode_fsm.sv
module sleep_mode_fsm
  import link_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wait_pulse,
  input  logic stop_pulse,
  input  logic wcm,
  input  logic ie,
  input  logic msg_ok,
  input  logic eof_seen,
  input  logic wake_edge,
  input  logic timer_done,
  output logic timer_start,
  output logic timer_run,
  output logic clk_en,
  output logic tx_inhibit,
  output logic irq,
  output logic nmi_wake,
  output logic rx_reliable
);
  pm_state_e state_q, state_d;
  logic clk_en_q, tx_inh_q, irq_q, nmi_q, rel_q;
  logic go_halt;

  assign go_halt = stop_pulse || (wait_pulse && wcm);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN: begin
        if (go_halt)         state_d = PM_HALT;
        else if (wait_pulse) state_d = PM_DOZE;
      end
      PM_DOZE:    if (msg_ok)     state_d = PM_RUN;
      PM_HALT:    if (wake_edge)  state_d = PM_RESTART;
      PM_RESTART: if (timer_done) state_d = PM_RUN;
      default:                    state_d = PM_RUN;
    endcase
  end

  assign timer_start = (state_q == PM_HALT) && wake_edge;
  assign timer_run   = (state_q == PM_RESTART);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PM_RUN;
      clk_en_q <= 1'b1;
      tx_inh_q <= 1'b0;
      irq_q    <= 1'b0;
      nmi_q    <= 1'b0;
      rel_q    <= 1'b1;
    end else begin
      state_q  <= state_d;
      clk_en_q <= (state_d == PM_RUN) || (state_d == PM_DOZE);
      tx_inh_q <= (state_d != PM_RUN);
      irq_q    <= (state_q == PM_DOZE) && msg_ok && ie;
      nmi_q    <= timer_start;
      if (state_q == PM_RUN && state_d == PM_DOZE)
        rel_q <= 1'b1;
      else if (state_q == PM_RUN && state_d == PM_HALT)
        rel_q <= !stop_pulse && eof_seen;
    end
  end

  assign clk_en      = clk_en_q;
  assign tx_inhibit  = tx_inh_q;
  assign irq         = irq_q;
  assign nmi_wake    = nmi_q;
  assign rx_reliable = rel_q;

  // R3
  gated_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> tx_inhibit);
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R4
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ie) && !tx_inhibit));
  // R5
  nmi_gated_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_wake |-> (!clk_en && !irq));
  // R8
  doze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_DOZE && !msg_ok) |=> (state_q == PM_DOZE));
endmodule

// File: rtl/link_sleep_mgr.sv
module link_sleep_mgr #(
  parameter int   RESTART_CYCLES = 4,
  parameter int   SYNC_STAGES    = 2,
  parameter logic BUS_PASSIVE    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_pulse,
  input  logic stop_pulse,
  input  logic wcm,
  input  logic ie,
  input  logic msg_ok,
  input  logic eof_seen,
  input  logic bus_level,
  output logic clk_en,
  output logic tx_inhibit,
  output logic irq,
  output logic nmi_wake,
  output logic rx_reliable
);
  logic wake_edge, timer_start, timer_run, timer_done;

  sleep_bus_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .BUS_PASSIVE (BUS_PASSIVE)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .bus_level (bus_level),
    .wake_edge (wake_edge)
  );

  sleep_restart_timer #(
    .RESTART_CYCLES (RESTART_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (timer_start),
    .run   (timer_run),
    .done  (timer_done)
  );

  sleep_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wait_pulse  (wait_pulse),
    .stop_pulse  (stop_pulse),
    .wcm         (wcm),
    .ie          (ie),
    .msg_ok      (msg_ok),
    .eof_seen    (eof_seen),
    .wake_edge   (wake_edge),
    .timer_done  (timer_done),
    .timer_start (timer_start),
    .timer_run   (timer_run),
    .clk_en      (clk_en),
    .tx_inhibit  (tx_inhibit),
    .irq         (irq),
    .nmi_wake    (nmi_wake),
    .rx_reliable (rx_reliable)
  );
endmodule

// File: tb/link_sleep_mgr_bench.sv
module link_sleep_mgr_bench;
  localparam int NCYC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_pulse = 1'b0, stop_pulse = 1'b0, wcm = 1'b0, ie = 1'b0;
  logic msg_ok = 1'b0, eof_seen = 1'b0, bus_level = 1'b0;
  logic clk_en, tx_inhibit, irq, nmi_wake, rx_reliable;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  link_sleep_mgr #(
    .RESTART_CYCLES (NCYC),
    .SYNC_STAGES    (2),
    .BUS_PASSIVE    (1'b0)
  ) u_link_sleep_mgr (
    .clk (clk), .rst (rst), .wait_pulse (wait_pulse), .stop_pulse (stop_pulse),
    .wcm (wcm), .ie (ie), .msg_ok (msg_ok), .eof_seen (eof_seen),
    .bus_level (bus_level), .clk_en (clk_en), .tx_inhibit (tx_inhibit),
    .irq (irq), .nmi_wake (nmi_wake), .rx_reliable (rx_reliable)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Bus wake from deep sleep, then restart interval (R5, R6, R7)
  task automatic wake_from_halt(input logic exp_rel);
    bus_level = 1'b1;
    repeat (3) step();
    check("R5", "nmi_wake on third edge", nmi_wake, 1'b1);
    check("R7", "rx_reliable at wake", rx_reliable, exp_rel);
    check("R6", "clk_en at wake", clk_en, 1'b0);
    for (int k = 1; k < NCYC; k++) begin
      step();
      check("R6", "clk_en held low", clk_en, 1'b0);
      check("R6", "tx_inhibit held", tx_inhibit, 1'b1);
      check("R5", "nmi_wake single", nmi_wake, 1'b0);
    end
    step();
    check("R6", "clk_en back", clk_en, 1'b1);
    check("R6", "tx_inhibit cleared", tx_inhibit, 1'b0);
    bus_level = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    repeat (3) step();
    // R1
    check("R1", "clk_en reset", clk_en, 1'b1);
    check("R1", "tx_inhibit reset", tx_inhibit, 1'b0);
    check("R1", "irq reset", irq, 1'b0);
    check("R1", "nmi reset", nmi_wake, 1'b0);
    check("R1", "rx_reliable reset", rx_reliable, 1'b1);
    rst = 1'b0;
    step();
    check("R1", "clk_en after reset", clk_en, 1'b1);
    check("R1", "tx_inhibit after reset", tx_inhibit, 1'b0);

    // R5: bus activity in run causes no wake interrupt
    bus_level = 1'b1;
    repeat (4) begin
      step();
      check("R5", "no nmi in run", nmi_wake, 1'b0);
    end
    bus_level = 1'b0;
    repeat (3) step();

    for (int route = 0; route < 2; route++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 2; i++)
          for (int e = 0; e < 2; e++) begin
            logic to_halt, exp_rel;
            to_halt = (route == 1) || (w == 1);
            exp_rel = to_halt ? ((route == 0) && (e == 1)) : 1'b1;
            wcm = w[0]; ie = i[0]; eof_seen = e[0];
            if (route == 0) wait_pulse = 1'b1; else stop_pulse = 1'b1;
            step();
            wait_pulse = 1'b0; stop_pulse = 1'b0;
            check(to_halt ? "R3" : "R2", "clk_en on entry", clk_en, !to_halt);
            check(to_halt ? "R3" : "R2", "tx_inhibit on entry", tx_inhibit, 1'b1);
            check("R7", "rx_reliable on entry", rx_reliable, exp_rel);
            eof_seen = !e[0];
            // R8: further instruction pulses ignored
            wait_pulse = 1'b1; stop_pulse = 1'b1;
            step();
            wait_pulse = 1'b0; stop_pulse = 1'b0;
            step();
            check("R8", "clk_en after stray pulses", clk_en, !to_halt);
            check("R8", "tx_inhibit after stray pulses", tx_inhibit, 1'b1);
            check("R7", "rx_reliable holds", rx_reliable, exp_rel);
            if (!to_halt) begin
              bus_level = 1'b1;
              repeat (4) begin
                step();
                check("R5", "no nmi in light sleep", nmi_wake, 1'b0);
                check("R2", "still inhibited", tx_inhibit, 1'b1);
              end
              bus_level = 1'b0;
              msg_ok = 1'b1;
              step();
              msg_ok = 1'b0;
              check("R4", "tx_inhibit cleared on msg", tx_inhibit, 1'b0);
              check("R4", "clk_en on msg", clk_en, 1'b1);
              check("R4", "irq follows ie", irq, i[0]);
              step();
              check("R4", "irq single cycle", irq, 1'b0);
              repeat (2) step();
            end else begin
              msg_ok = 1'b1;
              step();
              msg_ok = 1'b0;
              step();
              check("R5", "msg_ok ignored in deep sleep", clk_en, 1'b0);
              check("R5", "no irq in deep sleep", irq, 1'b0);
              wake_from_halt(exp_rel);
            end
          end

    // R3: simultaneous pulses, stop decides the route
    wcm = 1'b0; eof_seen = 1'b1;
    wait_pulse = 1'b1; stop_pulse = 1'b1;
    step();
    wait_pulse = 1'b0; stop_pulse = 1'b0;
    check("R3", "stop wins clk_en", clk_en, 1'b0);
    check("R7", "stop route unreliable", rx_reliable, 1'b0);
    wake_from_halt(1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule